// File: doc/BRIEF.md
# Dual-Bank XY Page Arbiter

This block owns two on-chip data memories, X and Y. Each memory is split into four pages, and the top two bits of a memory's word address select the page. Four request paths reach the memories. A system port can address either memory. A dedicated X port reaches only X, and a dedicated Y port reaches only Y. A shared local port can address either memory. Each cycle, the arbiter maps every active request to a memory and a page. When requests meet on the same page, a fixed priority picks the winner. Requests on different pages, or in different memories, are served together.

The dedicated ports and the local port complete in one cycle when they are not blocked. The system port holds its page for three cycles, and only then does it see ready. A request that loses keeps its request line high and is served as soon as the page is free. Local-port access is checked against two processor status inputs, a privilege bit and a DSP bit. A refused access is answered in one cycle with an error flag, and it writes nothing.

Top module: `xy_page_arb`

## Requirements
- R1: On the same page of the X memory, the system port wins over the X port, and the X port wins over the local port. Only the winner sees ready, and only the winner's write takes effect. The page is bits [AW-1:AW-2] of the memory word address.
- R2: On the same page of the Y memory, the system port wins over the Y port, and the Y port wins over the local port.
- R3: An X, Y or local request that is not blocked sees ready in the same cycle. Its write is stored at that clock edge. Read data is valid during the ready cycle.
- R4: An X-port access and a Y-port access are both served in the same cycle. A local access to one page of a memory is served in the same cycle as a dedicated-port access to another page of that memory.
- R5: A system request sees ready only in its third consecutive cycle, and its write is stored at that edge. The requested page is held for all three cycles. System address bit AW selects the memory: 0 is X, 1 is Y.
- R6: With the privilege input high, a local access is allowed at either local window. Local address bit AW selects the memory (0 is X). Local address bit AW+1 is the window bit (1 is the user XY window).
- R7: With the privilege input low and the DSP input high, a local access is allowed only when the window bit is 1. Otherwise it is refused.
- R8: With both mode inputs low, every local access is refused. A refused access sees ready and the error flag in the same cycle, and it writes nothing.
- R9: A losing requester sees ready low while it is blocked. It is served in the first cycle after the blocking request ends.
- R10: After reset, with no requests, all ready outputs and the error flag are low. The system wait count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| md | input | 1 | Processor privilege bit |
| dsp | input | 1 | Processor DSP mode bit |
| sys_req | input | 1 | System port request |
| sys_we | input | 1 | System port write enable |
| sys_addr | input | AW+1 | Bit AW selects the memory; bits below it are the word address |
| sys_wdata | input | DW | System write data |
| sys_rdata | output | DW | System read data |
| sys_rdy | output | 1 | System access completes |
| x_req | input | 1 | X port request |
| x_we | input | 1 | X port write enable |
| x_addr | input | AW | X memory word address |
| x_wdata | input | DW | X write data |
| x_rdata | output | DW | X read data |
| x_rdy | output | 1 | X access completes |
| y_req | input | 1 | Y port request |
| y_we | input | 1 | Y port write enable |
| y_addr | input | AW | Y memory word address |
| y_wdata | input | DW | Y write data |
| y_rdata | output | DW | Y read data |
| y_rdy | output | 1 | Y access completes |
| loc_req | input | 1 | Local port request |
| loc_we | input | 1 | Local port write enable |
| loc_addr | input | AW+2 | Bit AW+1 is the window bit, bit AW selects the memory, lower bits are the word address |
| loc_wdata | input | DW | Local write data |
| loc_rdata | output | DW | Local read data |
| loc_rdy | output | 1 | Local access completes or is refused |
| loc_err | output | 1 | Local access refused by mode |

## Verification
The assertions assume that a requester keeps its request, address and write data stable until it sees ready. This matters most for the system port, which the checks expect to hold its request for exactly one full three-cycle window before dropping it. The directed tasks change inputs only on falling edges. They hold each system request for exactly three cycles, and they raise a blocked request again on the next cycle rather than withdrawing it. Every conflict case therefore runs inside the handshake the checks assume.

// File: rtl/xy_page_arb.sv
`timescale 1ns/1ps
module xy_page_arb #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int SYS_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          md,
  input  logic          dsp,
  input  logic          sys_req,
  input  logic          sys_we,
  input  logic [AW:0]   sys_addr,
  input  logic [DW-1:0] sys_wdata,
  output logic [DW-1:0] sys_rdata,
  output logic          sys_rdy,
  input  logic          x_req,
  input  logic          x_we,
  input  logic [AW-1:0] x_addr,
  input  logic [DW-1:0] x_wdata,
  output logic [DW-1:0] x_rdata,
  output logic          x_rdy,
  input  logic          y_req,
  input  logic          y_we,
  input  logic [AW-1:0] y_addr,
  input  logic [DW-1:0] y_wdata,
  output logic [DW-1:0] y_rdata,
  output logic          y_rdy,
  input  logic          loc_req,
  input  logic          loc_we,
  input  logic [AW+1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  output logic          loc_rdy,
  output logic          loc_err
);

  localparam int PB    = 2;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (SYS_LAT > 1) ? $clog2(SYS_LAT) : 1;

  logic [PB-1:0] sys_pg, x_pg, y_pg, loc_pg;
  logic          sys_mem, loc_mem, loc_win, loc_ok, loc_gnt, ded_clash;
  logic [1:0]    sys_on;
  logic [CW-1:0] sys_cnt;

  assign sys_mem = sys_addr[AW];
  assign sys_pg  = sys_addr[AW-1 -: PB];
  assign x_pg    = x_addr[AW-1 -: PB];
  assign y_pg    = y_addr[AW-1 -: PB];
  assign loc_mem = loc_addr[AW];
  assign loc_win = loc_addr[AW+1];
  assign loc_pg  = loc_addr[AW-1 -: PB];
  assign sys_on  = {sys_req & sys_mem, sys_req & ~sys_mem};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                sys_cnt <= '0;
    else if (!sys_req || sys_rdy)              sys_cnt <= '0;
    else                                       sys_cnt <= sys_cnt + CW'(1);

  assign sys_rdy = sys_req && (sys_cnt == CW'(SYS_LAT-1));

  assign x_rdy = x_req && !(sys_on[0] && sys_pg == x_pg);
  assign y_rdy = y_req && !(sys_on[1] && sys_pg == y_pg);

  assign loc_ok    = md | (dsp & loc_win);
  assign ded_clash = loc_mem ? (y_req && y_pg == loc_pg) : (x_req && x_pg == loc_pg);
  assign loc_gnt   = loc_req && loc_ok && !(sys_on[loc_mem] && sys_pg == loc_pg) && !ded_clash;
  assign loc_err   = loc_req && !loc_ok;
  assign loc_rdy   = loc_gnt || loc_err;

  logic [1:0]          d_gnt, d_we;
  logic [AW-1:0]       d_addr [2];
  logic [DW-1:0]       d_wdata [2];
  logic [1:0][DW-1:0]  d_rd, s_rd, l_rd;

  assign d_gnt      = {y_rdy, x_rdy};
  assign d_we       = {y_we, x_we};
  assign d_addr[0]  = x_addr;
  assign d_addr[1]  = y_addr;
  assign d_wdata[0] = x_wdata;
  assign d_wdata[1] = y_wdata;

  for (genvar m = 0; m < 2; m++) begin : g_bank
    logic [DW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (sys_rdy && sys_we && sys_mem == 1'(m)) arr[sys_addr[AW-1:0]] <= sys_wdata;
      if (d_gnt[m] && d_we[m])                   arr[d_addr[m]]        <= d_wdata[m];
      if (loc_gnt && loc_we && loc_mem == 1'(m)) arr[loc_addr[AW-1:0]] <= loc_wdata;
    end
    assign d_rd[m] = arr[d_addr[m]];
    assign s_rd[m] = arr[sys_addr[AW-1:0]];
    assign l_rd[m] = arr[loc_addr[AW-1:0]];
  end

  assign x_rdata   = d_rd[0];
  assign y_rdata   = d_rd[1];
  assign sys_rdata = s_rd[sys_mem];
  assign loc_rdata = l_rd[loc_mem];

  AST_X_OVER_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rdy && !loc_err && !loc_addr[AW]) |-> !(x_req && x_addr[AW-1 -: PB] == loc_addr[AW-1 -: PB])); // R1
  AST_Y_OVER_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rdy && !loc_err && loc_addr[AW]) |-> !(y_req && y_addr[AW-1 -: PB] == loc_addr[AW-1 -: PB])); // R2
  AST_XY_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && y_req && !sys_req) |-> (x_rdy && y_rdy)); // R4
  AST_SYS_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rdy |-> sys_req); // R5
  AST_PRIV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && md) |-> !loc_err); // R6
  AST_REFUSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    loc_err |-> (loc_rdy && !md && !(dsp && loc_addr[AW+1]))); // R8
  AST_LOSER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && !x_rdy) |-> sys_req); // R9

  if (SYS_LAT > 1) begin : g_sys_chk
    AST_SYS_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_req) |-> !sys_rdy); // R5
    AST_SYS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rdy |=> !sys_rdy); // R5
  end

endmodule

// File: tb/sim_xy_page_arb.sv
`timescale 1ns/1ps
module sim_xy_page_arb;
  localparam int AW = 8, DW = 16;

  logic clk = 0, rst_n = 0, md = 0, dsp = 0;
  logic sys_req = 0, sys_we = 0, x_req = 0, x_we = 0, y_req = 0, y_we = 0, loc_req = 0, loc_we = 0;
  logic [AW:0]   sys_addr = '0;
  logic [AW-1:0] x_addr = '0, y_addr = '0;
  logic [AW+1:0] loc_addr = '0;
  logic [DW-1:0] sys_wdata = '0, x_wdata = '0, y_wdata = '0, loc_wdata = '0;
  logic [DW-1:0] sys_rdata, x_rdata, y_rdata, loc_rdata;
  logic sys_rdy, x_rdy, y_rdy, loc_rdy, loc_err;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xy_page_arb #(.AW(AW), .DW(DW), .SYS_LAT(3)) u0 (
    .clk, .rst_n, .md, .dsp,
    .sys_req, .sys_we, .sys_addr, .sys_wdata, .sys_rdata, .sys_rdy,
    .x_req, .x_we, .x_addr, .x_wdata, .x_rdata, .x_rdy,
    .y_req, .y_we, .y_addr, .y_wdata, .y_rdata, .y_rdy,
    .loc_req, .loc_we, .loc_addr, .loc_wdata, .loc_rdata, .loc_rdy, .loc_err);

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sys_req = 0; sys_we = 0; x_req = 0; x_we = 0; y_req = 0; y_we = 0; loc_req = 0; loc_we = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); idle(); #1;
    chk("R10 sys_rdy", sys_rdy, 0); chk("R10 x_rdy", x_rdy, 0);
    chk("R10 y_rdy", y_rdy, 0);     chk("R10 loc_rdy", loc_rdy, 0);
    chk("R10 loc_err", loc_err, 0);
  endtask

  task automatic t_single();
    @(negedge clk); x_req = 1; x_we = 1; x_addr = 8'h05; x_wdata = 16'h1234;
    md = 1; loc_req = 1; loc_we = 1; loc_addr = {1'b0, 1'b1, 8'h10}; loc_wdata = 16'hABCD; #1;
    chk("R3 x_rdy", x_rdy, 1); chk("R6 loc_rdy", loc_rdy, 1); chk("R6 loc_err", loc_err, 0);
    @(negedge clk); x_we = 0; loc_we = 0; #1;
    chk("R3 x_rdata", x_rdata, 16'h1234); chk("R6 loc_rdata", loc_rdata, 16'hABCD);
    @(negedge clk); idle();
  endtask

  task automatic t_parallel();
    @(negedge clk); md = 1;
    x_req = 1; x_we = 1; x_addr = 8'h41; x_wdata = 16'h1111;
    y_req = 1; y_we = 1; y_addr = 8'h42; y_wdata = 16'h2222;
    loc_req = 1; loc_we = 1; loc_addr = {1'b0, 1'b0, 8'h81}; loc_wdata = 16'h3333; #1;
    chk("R4 x_rdy", x_rdy, 1); chk("R4 y_rdy", y_rdy, 1); chk("R4 loc_rdy", loc_rdy, 1);
    @(negedge clk); x_we = 0; y_we = 0; loc_we = 0; #1;
    chk("R4 x_rdata", x_rdata, 16'h1111); chk("R4 y_rdata", y_rdata, 16'h2222);
    chk("R4 loc_rdata", loc_rdata, 16'h3333);
    @(negedge clk); idle();
  endtask

  task automatic t_sys();
    @(negedge clk); md = 1;
    sys_req = 1; sys_we = 1; sys_addr = {1'b1, 8'hC0}; sys_wdata = 16'h5A5A;
    y_req = 1; y_addr = 8'hC0;
    loc_req = 1; loc_addr = {1'b0, 1'b1, 8'hC4};
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R5 sys_rdy", sys_rdy, c == 2 ? 1 : 0);
      chk("R2 y_rdy blocked", y_rdy, 0);
      chk("R2 loc_rdy blocked", loc_rdy, 0);
      @(negedge clk);
    end
    sys_req = 0; sys_we = 0; #1;
    chk("R9 y_rdy retry", y_rdy, 1); chk("R5 y_rdata", y_rdata, 16'h5A5A);
    chk("R2 loc below y", loc_rdy, 0);
    @(negedge clk); y_req = 0; #1;
    chk("R9 loc_rdy retry", loc_rdy, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_xprio();
    @(negedge clk); md = 1;
    x_req = 1; x_we = 1; x_addr = 8'h20; x_wdata = 16'h7777;
    loc_req = 1; loc_we = 1; loc_addr = {1'b0, 1'b0, 8'h20}; loc_wdata = 16'h8888; #1;
    chk("R1 x_rdy", x_rdy, 1); chk("R1 loc_rdy", loc_rdy, 0);
    @(negedge clk); x_req = 0; x_we = 0; #1;
    chk("R9 loc_rdy", loc_rdy, 1);
    @(negedge clk); loc_req = 0; loc_we = 0; x_req = 1; #1;
    chk("R1 x_rdata", x_rdata, 16'h8888);
    @(negedge clk); idle();
    sys_req = 1; sys_addr = {1'b0, 8'h2F}; x_req = 1; x_addr = 8'h20;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R1 x below sys", x_rdy, 0);
      chk("R5 sys_rdy", sys_rdy, c == 2 ? 1 : 0);
      @(negedge clk);
    end
    sys_req = 0; #1;
    chk("R9 x_rdy after sys", x_rdy, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_modes();
    @(negedge clk); md = 0; dsp = 1;
    loc_req = 1; loc_we = 1; loc_addr = {1'b1, 1'b0, 8'h30}; loc_wdata = 16'hAAAA; #1;
    chk("R7 user window rdy", loc_rdy, 1); chk("R7 user window err", loc_err, 0);
    @(negedge clk); loc_addr = {1'b0, 1'b0, 8'h30}; loc_wdata = 16'hBBBB; #1;
    chk("R7 other window rdy", loc_rdy, 1); chk("R7 other window err", loc_err, 1);
    @(negedge clk); dsp = 0; loc_addr = {1'b1, 1'b0, 8'h30}; loc_wdata = 16'hCCCC; #1;
    chk("R8 refused rdy", loc_rdy, 1); chk("R8 refused err", loc_err, 1);
    @(negedge clk); idle(); x_req = 1; x_addr = 8'h30; #1;
    chk("R8 no write", x_rdata, 16'hAAAA);
    @(negedge clk); idle(); md = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_parallel();
    t_sys();
    t_xprio();
    t_modes();
    t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule